// File: doc/BRIEF.md
# Configurable Control Pin Function Multiplexer

This block drives five general control pins. A small bank of configuration registers holds one function code per pin, and each pin carries that one function. The available functions are:

- status levels: power-enable, sleep and RS485 driver enable;
- activity LED drives, which stretch short transmit and receive events into visible pulses;
- clocks taken from the 48 MHz system clock at full, half, quarter and eighth rate;
- the bit-bang read and write strobes;
- plain GPIO.

The register bank comes out of reset with a fixed default set of functions, standing in for settings loaded from non-volatile storage. A single-cycle write port can change one pin's function at a time.

Each function has its own rule for USB suspend. The power-enable and sleep outputs report it. LED outputs are forced dark while suspended. Divided clocks are held low. GPIO, strobes and driver enable are unaffected. A code that a pin cannot carry turns that pin's driver off. Pin 4 has no GPIO or strobe capability.

Top module: `ctl_pin_mux`

## Requirements
- R1: After reset the pin functions are these, all with the driver enabled: pin 0 = transmit LED (code 2), pin 1 = receive LED (code 3), pins 2 and 3 = power-enable (code 1), pin 4 = sleep (code 5). With idle inputs and the host not configured, every pin reads high.
- R2: A write with `cfg_we` high stores `cfg_code` for pin `cfg_idx`, and the pin shows the new function from the second rising edge after the write cycle. A write whose index is 5 or more changes nothing.
- R3: Power-enable (code 1) is low only while `usb_cfgd` is 1 and `suspend` is 0. Otherwise it is high.
- R4: Sleep (code 5) is low while `suspend` is 1 and high otherwise.
- R5: Transmit LED (code 2) and receive LED (code 3) go low on a `tx_act` or `rx_act` event, respectively. The low output lasts exactly `STRETCH_CYC` cycles after the last event, so a new event during the pulse restarts the count. While `suspend` is 1 the output stays high.
- R6: The combined LED (code 4) pulses low on either `tx_act` or `rx_act`.
- R7: Code 6 outputs the 48 MHz clock itself. Codes 7, 8 and 9 output 50% duty clocks at one half, one quarter and one eighth of that rate. While `suspend` is 1 all four are held low.
- R8: RS485 enable (code 0) follows `txden_req`. The transmitter raises that input one bit time before the start bit and drops it after the last stop bit.
- R9: Write strobe (code 11) follows `bb_wr_n` and read strobe (code 12) follows `bb_rd_n`, on pins 0 to 3.
- R10: GPIO (code 10) on pins 0 to 3 drives `gpio_out[i]` with driver enable `gpio_oe[i]`. `gpio_rd` returns `gpio_pin_i` through a two-stage synchronizer.
- R11: A code a pin cannot carry leaves that pin with its driver off (`pin_oe` 0). Such codes are 13 to 15 on any pin, and 10, 11 or 12 on pin 4.
- R12: Every function except the 48 MHz clock is registered. An input change at one rising edge reaches `pin_o` at that edge, or at the next edge for the LED functions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Pin index for the write |
| cfg_code | input | 4 | Function code to store |
| usb_cfgd | input | 1 | Host has configured the device |
| suspend | input | 1 | USB suspend state |
| tx_act | input | 1 | Transmit activity event |
| rx_act | input | 1 | Receive activity event |
| txden_req | input | 1 | RS485 driver-enable window from the transmitter |
| bb_wr_n | input | 1 | Bit-bang write strobe, active low |
| bb_rd_n | input | 1 | Bit-bang read strobe, active low |
| gpio_out | input | 4 | GPIO output values for pins 0 to 3 |
| gpio_oe | input | 4 | GPIO driver enables for pins 0 to 3 |
| gpio_pin_i | input | 4 | Pad input values for pins 0 to 3 |
| pin_o | output | 5 | Pin output values |
| pin_oe | output | 5 | Pin driver enables |
| gpio_rd | output | 4 | Synchronized pad input values |

## Verification
Most functions reach the pin one rising edge after their input changes, so the bench drives inputs at a falling edge and checks at the next falling edge. LED pulses pass through the stretch counter first, so they appear one edge later. The bench checks them by counting falling edges from the end of the event: low at the first, still low at the `STRETCH_CYC`-th, and high at the next. A configuration write and the GPIO read synchronizer each need two edges, and the bench waits for both before sampling. Divided clocks are checked by counting toggles and high samples over 17 consecutive falling edges, which makes the check independent of counter phase.

// File: rtl/ctl_pin_pkg.sv
`timescale 1ns/1ps
package ctl_pin_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    FN_TXDEN    = 4'd0,
    FN_PWREN_N  = 4'd1,
    FN_TXLED_N  = 4'd2,
    FN_RXLED_N  = 4'd3,
    FN_TRXLED_N = 4'd4,
    FN_SLEEP_N  = 4'd5,
    FN_CLK48    = 4'd6,
    FN_CLK24    = 4'd7,
    FN_CLK12    = 4'd8,
    FN_CLK6     = 4'd9,
    FN_GPIO     = 4'd10,
    FN_WRSTB    = 4'd11,
    FN_RDSTB    = 4'd12
  } pin_fn_e;

  // Signals shared by every pin slot, already combined with suspend.
  typedef struct packed {
    logic txden;
    logic pwren_n;
    logic sleep_n;
    logic txled_n;
    logic rxled_n;
    logic trxled_n;
    logic clk24;
    logic clk12;
    logic clk6;
    logic wr_n;
    logic rd_n;
  } pin_src_t;

  // full_pin: the pin can carry GPIO and strobe functions.
  function automatic logic fn_legal(input logic [CODE_W-1:0] code, input logic full_pin);
    return (code <= 4'd9) || (full_pin && (code <= 4'd12));
  endfunction

  function automatic logic [CODE_W-1:0] default_code(input int pin);
    case (pin)
      0:       return FN_TXLED_N;
      1:       return FN_RXLED_N;
      2, 3:    return FN_PWREN_N;
      default: return FN_SLEEP_N;
    endcase
  endfunction
endpackage

// File: rtl/cpm_cfg.sv
`timescale 1ns/1ps
module cpm_cfg
  import ctl_pin_pkg::*;
#(
  parameter int NUM_PINS = 5,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [CODE_W-1:0]                code,
  output logic [NUM_PINS-1:0][CODE_W-1:0]  codes
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        codes[i] <= default_code(i);
      else if (we && (int'(idx) == i))
        codes[i] <= code;
    end
  end

  AST_CFG_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (we && (int'(idx) >= NUM_PINS)) |=> $stable(codes)); // R2
endmodule

// File: rtl/cpm_clkdiv.sv
`timescale 1ns/1ps
module cpm_clkdiv #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STAGES-1:0] div
);
  logic [STAGES-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign div = cnt;

  AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (div[0] != $past(div[0]))); // R7
endmodule

// File: rtl/cpm_stretch.sv
`timescale 1ns/1ps
module cpm_stretch #(
  parameter int HOLD = 8,
  localparam int W = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ev,
  output logic active
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (ev)
      cnt <= W'(HOLD);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  AST_STRETCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    ev |=> active); // R5
endmodule

// File: rtl/cpm_pin_slot.sv
`timescale 1ns/1ps
module cpm_pin_slot
  import ctl_pin_pkg::*;
#(
  parameter bit FULL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  pin_src_t          src,
  input  logic              suspend,
  input  logic              gpio_o,
  input  logic              gpio_oe,
  output logic              pin_o,
  output logic              pin_oe
);
  logic o_nxt, oe_nxt, o_q, oe_q, c48_q;

  always_comb begin
    o_nxt  = 1'b1;
    oe_nxt = 1'b1;
    if (!fn_legal(code, FULL)) begin
      oe_nxt = 1'b0;
    end else begin
      unique case (pin_fn_e'(code))
        FN_TXDEN:    o_nxt = src.txden;
        FN_PWREN_N:  o_nxt = src.pwren_n;
        FN_TXLED_N:  o_nxt = src.txled_n;
        FN_RXLED_N:  o_nxt = src.rxled_n;
        FN_TRXLED_N: o_nxt = src.trxled_n;
        FN_SLEEP_N:  o_nxt = src.sleep_n;
        FN_CLK48:    o_nxt = 1'b0;
        FN_CLK24:    o_nxt = src.clk24;
        FN_CLK12:    o_nxt = src.clk12;
        FN_CLK6:     o_nxt = src.clk6;
        FN_GPIO: begin
          o_nxt  = gpio_o;
          oe_nxt = gpio_oe;
        end
        FN_WRSTB:    o_nxt = src.wr_n;
        FN_RDSTB:    o_nxt = src.rd_n;
        default:     oe_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_q   <= 1'b1;
      oe_q  <= 1'b0;
      c48_q <= 1'b0;
    end else begin
      o_q   <= o_nxt;
      oe_q  <= oe_nxt;
      c48_q <= (code == FN_CLK48) && !suspend;
    end
  end

  // The full-rate clock cannot pass through a register; it is gated by a registered select.
  assign pin_o  = c48_q ? clk : o_q;
  assign pin_oe = oe_q;

  AST_ILLEGAL_HIZ: assert property (@(posedge clk) disable iff (rst)
    !fn_legal(code, FULL) |=> !pin_oe); // R11
endmodule

// File: rtl/ctl_pin_mux.sv
`timescale 1ns/1ps
module ctl_pin_mux
  import ctl_pin_pkg::*;
#(
  parameter int STRETCH_CYC = 8,
  parameter int NUM_PINS    = 5,
  localparam int GPIO_PINS  = NUM_PINS - 1,
  localparam int IDX_W      = $clog2(NUM_PINS),
  localparam int NUM_LED    = 3,
  localparam int DIV_STAGES = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [CODE_W-1:0]    cfg_code,
  input  logic                 usb_cfgd,
  input  logic                 suspend,
  input  logic                 tx_act,
  input  logic                 rx_act,
  input  logic                 txden_req,
  input  logic                 bb_wr_n,
  input  logic                 bb_rd_n,
  input  logic [GPIO_PINS-1:0] gpio_out,
  input  logic [GPIO_PINS-1:0] gpio_oe,
  input  logic [GPIO_PINS-1:0] gpio_pin_i,
  output logic [NUM_PINS-1:0]  pin_o,
  output logic [NUM_PINS-1:0]  pin_oe,
  output logic [GPIO_PINS-1:0] gpio_rd
);
  logic [NUM_PINS-1:0][CODE_W-1:0] codes;
  logic [DIV_STAGES-1:0]           div;
  logic [NUM_LED-1:0]              led_ev, led_act;
  pin_src_t                        src;
  logic [GPIO_PINS-1:0]            sync1, sync2;

  cpm_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .code(cfg_code), .codes(codes)
  );

  cpm_clkdiv #(.STAGES(DIV_STAGES)) u_div (.clk(clk), .rst(rst), .div(div));

  // Event sources: 0 = transmit, 1 = receive, 2 = either.
  assign led_ev = {tx_act | rx_act, rx_act, tx_act};

  for (genvar k = 0; k < NUM_LED; k++) begin : g_led
    cpm_stretch #(.HOLD(STRETCH_CYC)) u_st (
      .clk(clk), .rst(rst), .ev(led_ev[k]), .active(led_act[k])
    );
  end

  always_comb begin
    src.txden    = txden_req;
    src.pwren_n  = !(usb_cfgd && !suspend);
    src.sleep_n  = !suspend;
    src.txled_n  = !(led_act[0] && !suspend);
    src.rxled_n  = !(led_act[1] && !suspend);
    src.trxled_n = !(led_act[2] && !suspend);
    src.clk24    = div[0] && !suspend;
    src.clk12    = div[1] && !suspend;
    src.clk6     = div[2] && !suspend;
    src.wr_n     = bb_wr_n;
    src.rd_n     = bb_rd_n;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic go, goe;
    if (i < GPIO_PINS) begin : g_io
      assign go  = gpio_out[i];
      assign goe = gpio_oe[i];
    end else begin : g_noio
      assign go  = 1'b0;
      assign goe = 1'b0;
    end

    cpm_pin_slot #(.FULL(i < GPIO_PINS)) u_slot (
      .clk(clk), .rst(rst), .code(codes[i]), .src(src), .suspend(suspend),
      .gpio_o(go), .gpio_oe(goe), .pin_o(pin_o[i]), .pin_oe(pin_oe[i])
    );

    AST_PWREN_SUSP: assert property (@(posedge clk) disable iff (rst)
      (codes[i] == FN_PWREN_N && suspend) |=> pin_o[i]); // R3
    AST_SLEEP_SUSP: assert property (@(posedge clk) disable iff (rst)
      (codes[i] == FN_SLEEP_N && suspend) |=> !pin_o[i]); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= gpio_pin_i;
      sync2 <= sync1;
    end
  end
  assign gpio_rd = sync2;

  AST_GPIO_SYNC: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |=> (gpio_rd == $past(gpio_pin_i, 2))); // R10
endmodule

// File: tb/ctl_pin_mux_test.sv
`timescale 1ns/1ps
module ctl_pin_mux_test;
  localparam int N = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 0;
  logic [2:0] cfg_idx = 0;
  logic [3:0] cfg_code = 0;
  logic       usb_cfgd = 0, suspend = 0, tx_act = 0, rx_act = 0, txden_req = 0;
  logic       bb_wr_n = 1, bb_rd_n = 1;
  logic [3:0] gpio_out = 0, gpio_oe = 0, gpio_pin_i = 0;
  logic [4:0] pin_o, pin_oe;
  logic [3:0] gpio_rd;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ctl_pin_mux #(.STRETCH_CYC(N)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_code(cfg_code),
    .usb_cfgd(usb_cfgd), .suspend(suspend), .tx_act(tx_act), .rx_act(rx_act),
    .txden_req(txden_req), .bb_wr_n(bb_wr_n), .bb_rd_n(bb_rd_n),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_pin_i(gpio_pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .gpio_rd(gpio_rd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Write is sampled at one edge; the function reaches the pin at the next.
  task automatic set_cfg(input int idx, input int code);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_code = 4'(code);
    tick();
    cfg_we = 0;
    tick();
  endtask

  task automatic t_reset;
    tick(2);
    chk("R1 reset pin_o", 32'(pin_o), 32'h1f);
    chk("R1 reset pin_oe", 32'(pin_oe), 32'h1f);
    chk("R12 gpio_rd reset", 32'(gpio_rd), 0);
  endtask

  task automatic t_pwren_sleep;
    usb_cfgd = 1; tick();
    chk("R3 pwren configured pin2", 32'(pin_o[2]), 0);
    chk("R3 pwren configured pin3", 32'(pin_o[3]), 0);
    suspend = 1; tick();
    chk("R3 pwren suspended", 32'(pin_o[2]), 1);
    chk("R4 sleep suspended", 32'(pin_o[4]), 0);
    suspend = 0; tick();
    chk("R4 sleep awake", 32'(pin_o[4]), 1);
    usb_cfgd = 0; tick();
    chk("R3 pwren unconfigured", 32'(pin_o[3]), 1);
  endtask

  task automatic t_cfg_ignore;
    logic [4:0] o0, oe0;
    o0 = pin_o; oe0 = pin_oe;
    set_cfg(5, 15);
    set_cfg(7, 13);
    tick(2);
    chk("R2 bad index pin_o", 32'(pin_o), 32'(o0));
    chk("R2 bad index pin_oe", 32'(pin_oe), 32'(oe0));
    set_cfg(2, 0);   // code 0: RS485 enable
    txden_req = 1; tick();
    chk("R2 write applied", 32'(pin_o[2]), 1);
    chk("R8 txden high", 32'(pin_o[2]), 1);
    txden_req = 0; tick();
    chk("R8 txden low", 32'(pin_o[2]), 0);
  endtask

  task automatic t_led;
    tx_act = 1; tick(); tx_act = 0;
    tick();
    chk("R5 txled first", 32'(pin_o[0]), 0);
    chk("R5 rxled idle", 32'(pin_o[1]), 1);
    tick(N - 1);
    chk("R12 R5 txled last low", 32'(pin_o[0]), 0);
    tick();
    chk("R5 txled released", 32'(pin_o[0]), 1);
    // restart in the middle of the pulse
    rx_act = 1; tick(); rx_act = 0;
    tick(3);
    rx_act = 1; tick(); rx_act = 0;
    tick(N);
    chk("R5 rxled restart held", 32'(pin_o[1]), 0);
    tick();
    chk("R5 rxled restart released", 32'(pin_o[1]), 1);
    // suspended: stays dark
    suspend = 1;
    tx_act = 1; tick(); tx_act = 0;
    tick();
    chk("R5 txled suspended", 32'(pin_o[0]), 1);
    tick(N + 2);
    suspend = 0;
    tick(2);
  endtask

  task automatic t_trxled;
    set_cfg(4, 4);
    rx_act = 1; tick(); rx_act = 0;
    tick();
    chk("R6 either on rx", 32'(pin_o[4]), 0);
    tick(N + 2);
    chk("R6 either idle", 32'(pin_o[4]), 1);
    tx_act = 1; tick(); tx_act = 0;
    tick();
    chk("R6 either on tx", 32'(pin_o[4]), 0);
    tick(N + 2);
  endtask

  task automatic count_clk(input int pin, output int tog, output int ones);
    logic prev;
    tog = 0; ones = 0;
    tick();
    prev = pin_o[pin];
    for (int i = 0; i < 16; i++) begin
      tick();
      if (pin_o[pin] != prev) tog++;
      if (pin_o[pin]) ones++;
      prev = pin_o[pin];
    end
  endtask

  task automatic t_clocks;
    int tg, on;
    set_cfg(1, 7);
    count_clk(1, tg, on);
    chk("R7 clk24 toggles", tg, 16);
    chk("R7 clk24 duty", on, 8);
    set_cfg(1, 8);
    count_clk(1, tg, on);
    chk("R7 clk12 toggles", tg, 8);
    chk("R7 clk12 duty", on, 8);
    set_cfg(1, 9);
    count_clk(1, tg, on);
    chk("R7 clk6 toggles", tg, 4);
    chk("R7 clk6 duty", on, 8);
    suspend = 1; tick();
    count_clk(1, tg, on);
    chk("R7 clk6 suspended", on, 0);
    suspend = 0;
    set_cfg(1, 6);
    chk("R7 clk48 low phase", 32'(pin_o[1]), 0);
    @(posedge clk); #1;
    chk("R7 clk48 high phase", 32'(pin_o[1]), 1);
    suspend = 1; tick(2);
    @(posedge clk); #1;
    chk("R7 clk48 suspended", 32'(pin_o[1]), 0);
    suspend = 0;
    tick();
  endtask

  task automatic t_strobes;
    set_cfg(3, 11);
    set_cfg(0, 12);
    bb_wr_n = 0; tick();
    chk("R9 wr strobe low", 32'(pin_o[3]), 0);
    chk("R9 rd strobe idle", 32'(pin_o[0]), 1);
    bb_wr_n = 1; bb_rd_n = 0; tick();
    chk("R9 wr strobe high", 32'(pin_o[3]), 1);
    chk("R9 rd strobe low", 32'(pin_o[0]), 0);
    bb_rd_n = 1; tick();
  endtask

  task automatic t_gpio;
    set_cfg(2, 10);
    gpio_out = 4'b0100; gpio_oe = 4'b0100; tick();
    chk("R10 gpio drive value", 32'(pin_o[2]), 1);
    chk("R10 gpio drive enable", 32'(pin_oe[2]), 1);
    gpio_oe = 4'b0000; tick();
    chk("R10 gpio released", 32'(pin_oe[2]), 0);
    gpio_pin_i = 4'b1010; tick();
    chk("R10 sync first stage", 32'(gpio_rd), 0);
    tick();
    chk("R10 sync second stage", 32'(gpio_rd), 32'hA);
  endtask

  task automatic t_illegal;
    set_cfg(4, 10);
    chk("R11 pin4 gpio", 32'(pin_oe[4]), 0);
    set_cfg(4, 11);
    chk("R11 pin4 strobe", 32'(pin_oe[4]), 0);
    set_cfg(1, 15);
    chk("R11 code 15", 32'(pin_oe[1]), 0);
    set_cfg(1, 3);
    chk("R11 legal restores", 32'(pin_oe[1]), 1);
  endtask

  initial begin
    tick(3);
    rst = 0;
    t_reset();
    t_pwren_sleep();
    t_cfg_ignore();
    t_led();
    t_trxled();
    t_clocks();
    t_strobes();
    t_gpio();
    t_illegal();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1600000;
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule